// File: doc/BRIEF.md
# Chained Accumulator with Rounding Preload

This block is the back end behind a product-sum stage. Each cycle it takes a signed product-sum word and a 64-bit word arriving from the previous stage of a chain. It adds or subtracts the product sum against that chain word. It can also add a feedback term, which is one of three values: the block's own previous result, a rounding constant of 2^RND_EXP, or zero. The registered total is driven on `result` and on `chain_out`, so that a row of these blocks can form an adder chain with no logic between them.

Three control inputs set the operation: `negate`, `accumulate` and `loadconst`. These controls and the data operands pass through the same optional input and pipeline registers, so they stay aligned. All of those registers run on the single block clock.

When `DUAL` is set, a second register sits in the feedback loop. The feedback term is then the result from two cycles earlier. Samples on alternate cycles therefore build up two independent, interleaved sums.

Top module: `chain_accum`

## Requirements
- R1: A synchronous active-low reset clears `result`, `chain_out`, every pipeline stage and the feedback state to zero.
- R2: With `accumulate` and `loadconst` low and `negate` low, the output is `chain_in` plus the sign-extended `prod_sum`, modulo 2^64. It appears IN_REG+PIPE_REG+1 clock edges after the inputs are presented.
- R3: With `negate` high, the sign-extended `prod_sum` is subtracted from `chain_in` instead of added. `negate` may change on every cycle.
- R4: With `accumulate` high, the feedback term is added to the sum. With DUAL=0 the feedback term is the previous result.
- R5: With `accumulate` low, any earlier accumulated state has no effect on the new output.
- R6: With `loadconst` high, the feedback term is the constant 2^RND_EXP instead of the stored result. `loadconst` and `accumulate` are never high together.
- R7: With DUAL=1 and `accumulate` high, the feedback term is the result from two cycles earlier. Even-cycle and odd-cycle samples therefore accumulate separately.
- R8: `chain_out` always carries the same value as `result`, and all sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prod_sum | input | PW | Signed product-sum word |
| chain_in | input | W | Chain word from the previous stage |
| negate | input | 1 | High: subtract the product sum |
| accumulate | input | 1 | High: add the feedback term |
| loadconst | input | 1 | High: use 2^RND_EXP as the feedback term |
| result | output | W | Registered sum |
| chain_out | output | W | Same value as result, for the next stage |

## Verification
The patterns start with single sums that have no feedback, using positive and negative product sums and non-zero chain words. These separate a correct sign extension and add/subtract choice from a wrong one.

Runs with `accumulate` held high show whether the feedback comes from the right register. Two instances are checked in parallel, one single-channel and one dual-channel, and the same stream exposes one-cycle versus two-cycle feedback. A rounding preload followed by accumulation confirms the constant's weight.

A saturating chain word confirms the wrap at 2^64. A reset in the middle of a run confirms that no stale feedback survives it.

// File: rtl/chain_accum.sv
module chain_accum #(
  parameter int W        = 64,
  parameter int PW       = 44,
  parameter int RND_EXP  = 8,
  parameter int IN_REG   = 1,
  parameter int PIPE_REG = 1,
  parameter bit DUAL     = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [PW-1:0] prod_sum,
  input  logic [W-1:0]         chain_in,
  input  logic                 negate,
  input  logic                 accumulate,
  input  logic                 loadconst,
  output logic [W-1:0]         result,
  output logic [W-1:0]         chain_out
);
  localparam int STG = IN_REG + PIPE_REG;
  localparam int VW  = 3 + W + PW;
  localparam logic [W-1:0] RND = {{(W-1){1'b0}}, 1'b1} << RND_EXP;

  logic [VW-1:0] vin, vd;
  assign vin = {negate, accumulate, loadconst, chain_in, prod_sum};

  generate
    if (STG == 0) begin : g_nodly
      assign vd = vin;
    end else begin : g_dly
      logic [VW-1:0] sr [STG];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < STG; i++) sr[i] <= '0;
        end else begin
          sr[0] <= vin;
          for (int i = 1; i < STG; i++) sr[i] <= sr[i-1];
        end
      end
      assign vd = sr[STG-1];
    end
  endgenerate

  logic          neg_d, acc_d, ld_d;
  logic [W-1:0]  chain_d, ps_ext, addend, fb_src, fb;
  logic [PW-1:0] ps_d;

  assign neg_d   = vd[VW-1];
  assign acc_d   = vd[VW-2];
  assign ld_d    = vd[VW-3];
  assign chain_d = vd[W+PW-1:PW];
  assign ps_d    = vd[PW-1:0];
  assign ps_ext  = {{(W-PW){ps_d[PW-1]}}, ps_d};
  assign addend  = neg_d ? (~ps_ext + 1'b1) : ps_ext;
  assign fb      = ld_d ? RND : (acc_d ? fb_src : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) result <= '0;
    else        result <= chain_d + addend + fb;
  end

  assign chain_out = result;

  generate
    if (DUAL) begin : g_dual
      logic [W-1:0] dbl_q;
      always_ff @(posedge clk) begin
        if (!rst_n) dbl_q <= '0;
        else        dbl_q <= result;
      end
      assign fb_src = dbl_q;

      p_two_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_d && !ld_d && chain_d == '0 && ps_d == '0) |=> result == $past(dbl_q))
        else $error("feedback not taken from two cycles back");
    end else begin : g_single
      assign fb_src = result;

      p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_d && !ld_d && chain_d == '0 && ps_d == '0) |=> $stable(result))
        else $error("accumulated value drifted with zero input");
    end
  endgenerate

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> result == '0)
    else $error("result not cleared by reset");

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(loadconst && accumulate))
    else $error("loadconst and accumulate both high");

  p_round_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_d && chain_d == '0 && ps_d == '0) |=> result == RND)
    else $error("rounding constant not loaded");

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_d && !ld_d && chain_d == '0 && ps_d == '0) |=> result == '0)
    else $error("state leaked while accumulate low");
endmodule

// File: tb/sim_chain_accum.sv
module sim_chain_accum;
  localparam int LAT = 3;
  localparam int RE  = 8;

  logic clk = 0, rst_n = 0;
  logic signed [43:0] prod_sum = '0;
  logic [63:0] chain_in = '0;
  logic negate = 0, accumulate = 0, loadconst = 0;
  logic [63:0] res0, co0, res1, co1;

  always #4 clk = ~clk;

  chain_accum #(.RND_EXP(RE), .DUAL(0)) u0 (
    .clk(clk), .rst_n(rst_n), .prod_sum(prod_sum), .chain_in(chain_in),
    .negate(negate), .accumulate(accumulate), .loadconst(loadconst),
    .result(res0), .chain_out(co0));

  chain_accum #(.RND_EXP(RE), .DUAL(1)) u1 (
    .clk(clk), .rst_n(rst_n), .prod_sum(prod_sum), .chain_in(chain_in),
    .negate(negate), .accumulate(accumulate), .loadconst(loadconst),
    .result(res1), .chain_out(co1));

  int n_chk = 0, n_bad = 0;
  logic [63:0] q0[$], q1[$];
  string qt[$];
  logic [63:0] m0 = '0, r1 = '0, p1 = '0;

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit n, input bit a, input bit l, input logic [63:0] c,
                      input longint p, input string tag);
    logic [63:0] add, fb, v;
    @(negedge clk);
    if (q0.size() == LAT) begin
      string t;
      logic [63:0] e0, e1;
      t = qt.pop_front(); e0 = q0.pop_front(); e1 = q1.pop_front();
      chk(t, "u0.result", res0, e0);
      chk("R8", "u0.chain_out", co0, e0);
      chk(t == "R4" ? "R7" : t, "u1.result", res1, e1);
      chk("R8", "u1.chain_out", co1, e1);
    end
    negate = n; accumulate = a; loadconst = l; chain_in = c; prod_sum = p[43:0];
    add = n ? -p : p;
    fb = l ? (64'd1 << RE) : (a ? m0 : 64'd0);
    v = c + add + fb; m0 = v; q0.push_back(v);
    fb = l ? (64'd1 << RE) : (a ? p1 : 64'd0);
    v = c + add + fb; p1 = r1; r1 = v; q1.push_back(v);
    qt.push_back(tag);
  endtask

  task automatic flush();
    for (int i = 0; i < LAT; i++) step(0, 0, 0, 0, 0, "R5");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; negate = 0; accumulate = 0; loadconst = 0; chain_in = '0; prod_sum = '0;
    repeat (2) @(negedge clk);
    chk("R1", "u0.result", res0, 64'd0);
    chk("R1", "u0.chain_out", co0, 64'd0);
    chk("R1", "u1.result", res1, 64'd0);
    chk("R1", "u1.chain_out", co1, 64'd0);
    rst_n = 1;
    q0.delete(); q1.delete(); qt.delete();
    m0 = '0; r1 = '0; p1 = '0;
  endtask

  task automatic t_plain();
    step(0, 0, 0, 64'd1000, 25, "R2");
    step(0, 0, 0, 64'd0, -7, "R2");
    step(0, 0, 0, 64'h0000_1234_0000_0000, -64'd5000, "R2");
    step(0, 0, 0, 64'hFFFF_FFFF_FFFF_FF00, 300, "R2");
    flush();
  endtask

  task automatic t_negate();
    step(1, 0, 0, 64'd1000, 25, "R3");
    step(0, 0, 0, 64'd1000, 25, "R3");
    step(1, 0, 0, 64'd10, -40, "R3");
    step(1, 0, 0, 64'd0, 64'sd8796093022207, "R3");
    flush();
  endtask

  task automatic t_accum();
    step(0, 0, 0, 64'd0, 100, "R4");
    step(0, 0, 0, 64'd0, 200, "R4");
    for (int i = 0; i < 6; i++) step(i % 3 == 2, 1, 0, 64'd3, 10 + i, "R4");
    step(0, 1, 0, 64'd0, 0, "R4");
    step(0, 1, 0, 64'd0, 0, "R4");
    step(0, 0, 0, 64'd7, 1, "R5");
    step(0, 0, 0, 64'd0, 0, "R5");
    flush();
  endtask

  task automatic t_round();
    step(0, 0, 1, 64'd0, 0, "R6");
    step(0, 0, 1, 64'd0, 0, "R6");
    step(0, 1, 0, 64'd0, 0, "R6");
    step(0, 1, 0, 64'd0, 37, "R6");
    step(1, 0, 1, 64'd20, 5, "R6");
    step(0, 1, 0, 64'd0, 0, "R6");
    flush();
  endtask

  task automatic t_dual();
    step(0, 0, 0, 64'd0, 1000, "R7");
    step(0, 0, 0, 64'd0, 1, "R7");
    for (int i = 0; i < 8; i++) step(0, 1, 0, 64'd0, (i % 2) ? 2 : 500, "R7");
    flush();
  endtask

  task automatic t_wrap();
    step(0, 0, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R8");
    step(0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 1, "R8");
    step(1, 0, 0, 64'd0, 1, "R8");
    flush();
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none
    do_reset();
    t_plain();
    t_negate();
    t_accum();
    t_round();
    t_dual();
    t_wrap();
    step(0, 0, 0, 64'd0, 99, "R4");
    step(0, 1, 0, 64'd0, 1, "R4");
    do_reset();
    step(0, 1, 0, 64'd0, 0, "R1");
    step(0, 1, 0, 64'd0, 0, "R1");
    flush();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule